// File: doc/BRIEF.md
# Privileged Register Access Unit

This block holds the bank of privileged processor state that supervisor code reaches through move-to and move-from commands. A caller presents a register number, a direction bit and a 64-bit value for one cycle. One cycle later the block answers with read data, the prior contents for the registers that report them, and an error flag when the access breaks that register's rules.

Each register has its own rules. Some fields are narrow and come back sign-extended. Some registers only accept reads, and some only accept writes. A few depend on a feature input or on the processor's privileged-mode bit. Several use special update semantics: a nibble that is first masked and then set, a status register that mixes clear-by-one bits with directly written bits, and a request register whose written value selects which summary bit to set. Writes to the translation-invalidate commands produce one-cycle flush pulses for an external TLB.

Some values come from outside and are only read here: the address-space number, the context block base, the page-table base and the hardware machine-check events. The processor identity is a parameter.

Top module: `priv_reg_bank`

## Requirements
- R1: Every response (`rsp_valid`, `rsp_rdata`, `rsp_old`, `rsp_old_valid`, `rsp_err`, flush outputs) is registered and appears the cycle after `req_valid`; with no request all of them are low or zero, and after reset all outputs are zero.
- R2: The two 4-bit asynchronous-trap registers (enable at number 1, summary at number 2) take the value (old AND wdata[3:0]) OR wdata[7:4] on a write; that write returns the old value sign-extended from bit 3 with `rsp_old_valid`=1, and a read returns the field sign-extended from bit 3.
- R3: The 5-bit priority level (number 5) takes wdata[4:0] on a write and returns the old value sign-extended from bit 4 with `rsp_old_valid`=1; a read sign-extends from bit 4, and the field changes only when it is written.
- R4: In the machine-check status (number 7, 5 bits, read sign-extended from bit 4), a write clears each of bits 2..0 whose wdata bit is 1 and loads bits 4..3 from wdata[4:3]; `mchk_event[i]` sets bit i, and an event wins over a clear in the same cycle.
- R5: A write to the software-interrupt request (number 12) with n = wdata[3:0] nonzero sets bit n of the 16-bit summary (number 13); n = 0 sets nothing; the summary reads sign-extended from bit 15.
- R6: The FP-enable bit (number 3) reads sign-extended from bit 0, the 32-bit system control base (number 11) from bit 31, and the 48-bit context block base input (number 8) from bit 47.
- R7: Reading a write-only number (4 IPI request, 12, 16..20 invalidates) flags an error; writing a read-only number (0 address space, 8, 10 page-table base, 13, 24 processor identity) flags an error and changes nothing.
- R8: The virtual bound (number 22) and system page-table base (number 15) are read/write only while `feat_bound` is 1 and flag an error otherwise; the address space number (number 0) reads `ctx_asn` when `feat_asn` is 1 and 0 when it is 0.
- R9: The kernel stack pointer (number 6) may be read or written only while `priv_mode` is 1; otherwise the access flags an error.
- R10: Writes to 16 and 17 pulse `flush_all` for one cycle; writes to 18, 19 and 20 pulse `flush_one` for one cycle with `flush_addr` equal to the written value; the two pulses are never high together.
- R11: A number outside 0..26 flags an error on read and write and changes no state.
- R12: The plain 64-bit registers (9 processor base, 14 supervisor stack, 21 user stack, 23 virtual page-table base, 25 executive stack) return what was last written; number 26 (performance) reads 0, and a write to it returns old value 0 with `rsp_old_valid`=1; number 10 reads `ctx_ptbr`; number 24 reads the `CPU_ID` parameter.
- R13: An errored access returns zero read data, `rsp_old_valid`=0 and no flush pulse; a write that reports no old value returns `rsp_old`=0 and `rsp_old_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access strobe |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_sel | input | SEL_W | Register number |
| req_wdata | input | 64 | Write value |
| feat_asn | input | 1 | Address-space numbers implemented |
| feat_bound | input | 1 | Virtual bound and system page-table base implemented |
| priv_mode | input | 1 | Processor is in privileged mode |
| ctx_asn | input | 8 | Current address space number |
| ctx_pcbb | input | 48 | Context block base |
| ctx_ptbr | input | 64 | Page-table base |
| mchk_event | input | 3 | Hardware machine-check event set pulses |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | 64 | Read data |
| rsp_old | output | 64 | Previous value for registers that report one |
| rsp_old_valid | output | 1 | rsp_old carries a value |
| rsp_err | output | 1 | Illegal access |
| flush_all | output | 1 | Invalidate-all pulse |
| flush_one | output | 1 | Invalidate-single pulse |
| flush_addr | output | 64 | Address to invalidate with flush_one |

## Verification
The machine-check status register can be written by software and set by a hardware event in the same cycle, and those two updates touch the same bits. The bench first sets bits through an event pulse alone. It then issues a write that clears bit 1 while `mchk_event` sets bit 1 in that same cycle. A later read must show bit 1 still set, with bits 4..3 taken from the write, which shows that the event won over the clear while the directly written bits were still applied.

// File: rtl/priv_reg_bank.sv
module priv_reg_bank #(
  parameter int SEL_W = 5,
  parameter logic [63:0] CPU_ID = 64'h3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [63:0]      req_wdata,
  input  logic             feat_asn,
  input  logic             feat_bound,
  input  logic             priv_mode,
  input  logic [7:0]       ctx_asn,
  input  logic [47:0]      ctx_pcbb,
  input  logic [63:0]      ctx_ptbr,
  input  logic [2:0]       mchk_event,
  output logic             rsp_valid,
  output logic [63:0]      rsp_rdata,
  output logic [63:0]      rsp_old,
  output logic             rsp_old_valid,
  output logic             rsp_err,
  output logic             flush_all,
  output logic             flush_one,
  output logic [63:0]      flush_addr
);
  localparam logic [SEL_W-1:0] N_ASN    = SEL_W'(0);
  localparam logic [SEL_W-1:0] N_TRAPEN = SEL_W'(1);
  localparam logic [SEL_W-1:0] N_TRAPSM = SEL_W'(2);
  localparam logic [SEL_W-1:0] N_FPEN   = SEL_W'(3);
  localparam logic [SEL_W-1:0] N_IPI    = SEL_W'(4);
  localparam logic [SEL_W-1:0] N_PRIO   = SEL_W'(5);
  localparam logic [SEL_W-1:0] N_KSTK   = SEL_W'(6);
  localparam logic [SEL_W-1:0] N_MCHK   = SEL_W'(7);
  localparam logic [SEL_W-1:0] N_CTXB   = SEL_W'(8);
  localparam logic [SEL_W-1:0] N_CPUB   = SEL_W'(9);
  localparam logic [SEL_W-1:0] N_PTB    = SEL_W'(10);
  localparam logic [SEL_W-1:0] N_SCB    = SEL_W'(11);
  localparam logic [SEL_W-1:0] N_SWREQ  = SEL_W'(12);
  localparam logic [SEL_W-1:0] N_SWSUM  = SEL_W'(13);
  localparam logic [SEL_W-1:0] N_SSTK   = SEL_W'(14);
  localparam logic [SEL_W-1:0] N_SYSPT  = SEL_W'(15);
  localparam logic [SEL_W-1:0] N_INVA   = SEL_W'(16);
  localparam logic [SEL_W-1:0] N_INVAP  = SEL_W'(17);
  localparam logic [SEL_W-1:0] N_INV1   = SEL_W'(18);
  localparam logic [SEL_W-1:0] N_INV1D  = SEL_W'(19);
  localparam logic [SEL_W-1:0] N_INV1I  = SEL_W'(20);
  localparam logic [SEL_W-1:0] N_USTK   = SEL_W'(21);
  localparam logic [SEL_W-1:0] N_VBND   = SEL_W'(22);
  localparam logic [SEL_W-1:0] N_VPTB   = SEL_W'(23);
  localparam logic [SEL_W-1:0] N_CPUID  = SEL_W'(24);
  localparam logic [SEL_W-1:0] N_ESTK   = SEL_W'(25);
  localparam logic [SEL_W-1:0] N_PERF   = SEL_W'(26);

  logic [3:0]  trap_en_q, trap_sm_q;
  logic        fpen_q;
  logic [4:0]  prio_q, mchk_q;
  logic [31:0] scb_q;
  logic [15:0] swsum_q;
  logic [63:0] kstk_q, cpub_q, sstk_q, ustk_q, estk_q, syspt_q, vbnd_q, vptb_q;

  logic        wr, rd, bad, has_old, inv_all, inv_one, unknown;
  logic [63:0] rval, oval;

  assign wr = req_valid & req_write;
  assign rd = req_valid & ~req_write;

  function automatic logic [3:0] trap_next(input logic [3:0] old, input logic [63:0] v);
    return (old & v[3:0]) | v[7:4];
  endfunction

  always_comb begin
    bad     = 1'b0;
    has_old = 1'b0;
    inv_all = 1'b0;
    inv_one = 1'b0;
    unknown = 1'b0;
    rval    = '0;
    oval    = '0;
    case (req_sel)
      N_ASN:    begin bad = req_write; rval = feat_asn ? {56'd0, ctx_asn} : '0; end
      N_TRAPEN: begin rval = {{60{trap_en_q[3]}}, trap_en_q}; oval = rval; has_old = 1'b1; end
      N_TRAPSM: begin rval = {{60{trap_sm_q[3]}}, trap_sm_q}; oval = rval; has_old = 1'b1; end
      N_FPEN:   rval = {64{fpen_q}};
      N_IPI:    bad = ~req_write;
      N_PRIO:   begin rval = {{59{prio_q[4]}}, prio_q}; oval = rval; has_old = 1'b1; end
      N_KSTK:   begin bad = ~priv_mode; rval = kstk_q; end
      N_MCHK:   rval = {{59{mchk_q[4]}}, mchk_q};
      N_CTXB:   begin bad = req_write; rval = {{16{ctx_pcbb[47]}}, ctx_pcbb}; end
      N_CPUB:   rval = cpub_q;
      N_PTB:    begin bad = req_write; rval = ctx_ptbr; end
      N_SCB:    rval = {{32{scb_q[31]}}, scb_q};
      N_SWREQ:  bad = ~req_write;
      N_SWSUM:  begin bad = req_write; rval = {{48{swsum_q[15]}}, swsum_q}; end
      N_SSTK:   rval = sstk_q;
      N_SYSPT:  begin bad = ~feat_bound; rval = syspt_q; end
      N_INVA,
      N_INVAP:  begin bad = ~req_write; inv_all = 1'b1; end
      N_INV1,
      N_INV1D,
      N_INV1I:  begin bad = ~req_write; inv_one = 1'b1; end
      N_USTK:   rval = ustk_q;
      N_VBND:   begin bad = ~feat_bound; rval = vbnd_q; end
      N_VPTB:   rval = vptb_q;
      N_CPUID:  begin bad = req_write; rval = CPU_ID; end
      N_ESTK:   rval = estk_q;
      N_PERF:   has_old = 1'b1;
      default:  begin bad = 1'b1; unknown = 1'b1; end
    endcase
  end

  logic ok_wr;
  assign ok_wr = wr & ~bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      rsp_old       <= '0;
      rsp_old_valid <= 1'b0;
      rsp_err       <= 1'b0;
      flush_all     <= 1'b0;
      flush_one     <= 1'b0;
      flush_addr    <= '0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_err       <= req_valid & bad;
      rsp_rdata     <= (rd & ~bad) ? rval : '0;
      rsp_old       <= (ok_wr & has_old) ? oval : '0;
      rsp_old_valid <= ok_wr & has_old;
      flush_all     <= ok_wr & inv_all;
      flush_one     <= ok_wr & inv_one;
      flush_addr    <= (ok_wr & inv_one) ? req_wdata : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_en_q <= '0;
      trap_sm_q <= '0;
      fpen_q    <= 1'b0;
      prio_q    <= '0;
      mchk_q    <= '0;
      scb_q     <= '0;
      swsum_q   <= '0;
      kstk_q    <= '0;
      cpub_q    <= '0;
      sstk_q    <= '0;
      ustk_q    <= '0;
      estk_q    <= '0;
      syspt_q   <= '0;
      vbnd_q    <= '0;
      vptb_q    <= '0;
    end else begin
      if (ok_wr) begin
        case (req_sel)
          N_TRAPEN: trap_en_q <= trap_next(trap_en_q, req_wdata);
          N_TRAPSM: trap_sm_q <= trap_next(trap_sm_q, req_wdata);
          N_FPEN:   fpen_q    <= req_wdata[0];
          N_PRIO:   prio_q    <= req_wdata[4:0];
          N_KSTK:   kstk_q    <= req_wdata;
          N_CPUB:   cpub_q    <= req_wdata;
          N_SCB:    scb_q     <= req_wdata[31:0];
          N_SWREQ:  if (req_wdata[3:0] != 4'd0) swsum_q[req_wdata[3:0]] <= 1'b1;
          N_SSTK:   sstk_q    <= req_wdata;
          N_SYSPT:  syspt_q   <= req_wdata;
          N_USTK:   ustk_q    <= req_wdata;
          N_VBND:   vbnd_q    <= req_wdata;
          N_VPTB:   vptb_q    <= req_wdata;
          N_ESTK:   estk_q    <= req_wdata;
          default:  ;
        endcase
      end
      if (ok_wr && req_sel == N_MCHK)
        mchk_q <= {req_wdata[4:3], (mchk_q[2:0] & ~req_wdata[2:0]) | mchk_event};
      else
        mchk_q <= {mchk_q[4:3], mchk_q[2:0] | mchk_event};
    end
  end

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R1
  AST_FLUSH_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(flush_all && flush_one)); // R10
  AST_FLUSH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) (flush_all || flush_one) |-> (rsp_valid && !rsp_err)); // R10
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) rsp_err |-> (rsp_rdata == 64'd0 && !rsp_old_valid && !flush_all && !flush_one)); // R13
  AST_PRIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(wr && req_sel == N_PRIO) |=> $stable(prio_q)); // R3
  AST_MCHK_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n) (mchk_event != 3'd0) |=> ((mchk_q[2:0] & $past(mchk_event)) == $past(mchk_event))); // R4
  AST_UNKNOWN_INERT: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && unknown) |=> ($stable(trap_en_q) && $stable(prio_q) && $stable(swsum_q) && $stable(vptb_q))); // R11
endmodule

// File: tb/tb_priv_reg_bank.sv
`timescale 1ns/1ps
module tb_priv_reg_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]  req_sel = '0;
  logic [63:0] req_wdata = '0;
  logic        feat_asn = 1'b0, feat_bound = 1'b0, priv_mode = 1'b0;
  logic [7:0]  ctx_asn = 8'h2A;
  logic [47:0] ctx_pcbb = 48'h8000_0000_1234;
  logic [63:0] ctx_ptbr = 64'h0000_0123_4560_0000;
  logic [2:0]  mchk_event = '0;
  logic        rsp_valid, rsp_old_valid, rsp_err, flush_all, flush_one;
  logic [63:0] rsp_rdata, rsp_old, flush_addr;

  always #2 clk = ~clk;

  priv_reg_bank dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_sel(req_sel), .req_wdata(req_wdata), .feat_asn(feat_asn),
    .feat_bound(feat_bound), .priv_mode(priv_mode), .ctx_asn(ctx_asn),
    .ctx_pcbb(ctx_pcbb), .ctx_ptbr(ctx_ptbr), .mchk_event(mchk_event),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_old(rsp_old),
    .rsp_old_valid(rsp_old_valid), .rsp_err(rsp_err), .flush_all(flush_all),
    .flush_one(flush_one), .flush_addr(flush_addr)
  );

  typedef struct {
    logic [63:0] rdata, old, faddr;
    logic        ov, err, fa, fo;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, fails = 0;
  logic [2:0] pend_ev = '0;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  task automatic acc(input logic w, input int sel, input logic [63:0] wd,
                     input logic [63:0] er, input logic [63:0] eo, input logic eov,
                     input logic ee, input logic efa, input logic efo, input string tag);
    exp_t e;
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = w; req_sel = sel[4:0]; req_wdata = wd;
    mchk_event = pend_ev; pend_ev = '0;
    e.rdata = er; e.old = eo; e.ov = eov; e.err = ee; e.fa = efa; e.fo = efo;
    e.faddr = efo ? wd : 64'd0; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk); #1;
    req_valid = 1'b0; mchk_event = '0;
  endtask

  task automatic rd_ok(input int sel, input logic [63:0] er, input string tag);
    acc(1'b0, sel, 64'd0, er, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask
  task automatic wr_ok(input int sel, input logic [63:0] wd, input string tag);
    acc(1'b1, sel, wd, 64'd0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask
  task automatic wr_old(input int sel, input logic [63:0] wd, input logic [63:0] eo, input string tag);
    acc(1'b1, sel, wd, 64'd0, eo, 1'b1, 1'b0, 1'b0, 1'b0, tag);
  endtask
  task automatic bad(input logic w, input int sel, input string tag);
    acc(w, sel, 64'hDEAD_BEEF_0000_00FF, 64'd0, 64'd0, 1'b0, 1'b1, 1'b0, 1'b0, tag);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R1 unexpected response rdata=%h err=%b expected none", rsp_rdata, rsp_err);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (rsp_rdata !== e.rdata || rsp_old !== e.old || rsp_old_valid !== e.ov ||
              rsp_err !== e.err || flush_all !== e.fa || flush_one !== e.fo || flush_addr !== e.faddr) begin
            fails++;
            $display("FAIL %s actual rdata=%h old=%h ov=%b err=%b fa=%b fo=%b addr=%h expected rdata=%h old=%h ov=%b err=%b fa=%b fo=%b addr=%h",
                     e.tag, rsp_rdata, rsp_old, rsp_old_valid, rsp_err, flush_all, flush_one, flush_addr,
                     e.rdata, e.old, e.ov, e.err, e.fa, e.fo, e.faddr);
          end
        end
      end else begin
        checks++;
        if (flush_all || flush_one || rsp_err || rsp_old_valid) begin
          fails++;
          $display("FAIL R1 idle outputs fa=%b fo=%b err=%b ov=%b expected all 0", flush_all, flush_one, rsp_err, rsp_old_valid);
        end
      end
    end
  end

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_rdata !== 64'd0 || rsp_err !== 1'b0 || flush_all !== 1'b0 || flush_one !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs valid=%b rdata=%h err=%b expected 0", rsp_valid, rsp_rdata, rsp_err);
    end
    rst_n = 1'b1;

    rd_ok(1, 64'd0, "R2 trap enable reset");
    wr_old(1, 64'hA5, 64'd0, "R2 trap enable write A5");
    rd_ok(1, 64'hFFFF_FFFF_FFFF_FFFA, "R2 trap enable sext");
    wr_old(1, 64'h03, 64'hFFFF_FFFF_FFFF_FFFA, "R2 trap enable mask");
    rd_ok(1, 64'd2, "R2 trap enable after mask");
    wr_old(2, 64'h70, 64'd0, "R2 trap summary set");
    rd_ok(2, 64'd7, "R2 trap summary read");

    wr_old(5, 64'h1F3, 64'd0, "R3 prio write");
    rd_ok(5, 64'hFFFF_FFFF_FFFF_FFF3, "R3 prio sext");
    wr_old(5, 64'h05, 64'hFFFF_FFFF_FFFF_FFF3, "R3 prio old");
    rd_ok(5, 64'd5, "R3 prio read");

    wr_ok(3, 64'h3, "R6 fp enable write");
    rd_ok(3, ONES, "R6 fp enable sext");
    wr_ok(11, 64'h1234_5678_9ABC_DEF0, "R6 scb write");
    rd_ok(11, 64'hFFFF_FFFF_9ABC_DEF0, "R6 scb sext32");
    rd_ok(8, 64'hFFFF_8000_0000_1234, "R6 ctx base sext48");

    wr_ok(12, 64'h5, "R5 swi req 5");
    wr_ok(12, 64'h0, "R5 swi req 0");
    wr_ok(12, 64'hF, "R5 swi req 15");
    rd_ok(13, 64'hFFFF_FFFF_FFFF_8020, "R5 swi summary");
    bad(1'b0, 12, "R7 read swi req");

    @(posedge clk); #1; mchk_event = 3'b110;
    @(posedge clk); #1; mchk_event = 3'b000;
    rd_ok(7, 64'd6, "R4 mchk after event");
    wr_ok(7, 64'h0C, "R4 mchk clear2 set3");
    rd_ok(7, 64'h0A, "R4 mchk read A");
    pend_ev = 3'b010;
    wr_ok(7, 64'h02, "R4 mchk clear vs event");
    rd_ok(7, 64'h02, "R4 mchk event wins");
    wr_ok(7, 64'h18, "R4 mchk set high");
    rd_ok(7, 64'hFFFF_FFFF_FFFF_FFFA, "R4 mchk sext");

    bad(1'b0, 16, "R7 read inval all");
    bad(1'b0, 4, "R7 read ipi");
    bad(1'b1, 0, "R7 write asn");
    bad(1'b1, 8, "R7 write ctx base");
    bad(1'b1, 10, "R7 write ptb");
    bad(1'b1, 13, "R7 write swi summary");
    rd_ok(13, 64'hFFFF_FFFF_FFFF_8020, "R7 swi summary unchanged");
    bad(1'b1, 24, "R7 write cpu id");
    wr_ok(4, 64'h1, "R7 write ipi accepted");

    bad(1'b0, 22, "R8 vbound disabled read");
    bad(1'b1, 15, "R8 syspt disabled write");
    rd_ok(0, 64'd0, "R8 asn feature off");
    feat_bound = 1'b1; feat_asn = 1'b1;
    wr_ok(22, 64'h0000_7FFF_0000_0000, "R8 vbound write");
    rd_ok(22, 64'h0000_7FFF_0000_0000, "R8 vbound read");
    wr_ok(15, 64'h00AB_CD00_0000_0000, "R8 syspt write");
    rd_ok(15, 64'h00AB_CD00_0000_0000, "R8 syspt read");
    rd_ok(0, 64'h2A, "R8 asn feature on");
    feat_bound = 1'b0;
    bad(1'b0, 22, "R8 vbound disabled again");

    bad(1'b1, 6, "R9 kstack write user");
    bad(1'b0, 6, "R9 kstack read user");
    priv_mode = 1'b1;
    wr_ok(6, 64'hFFFF_FC00_0000_1000, "R9 kstack write priv");
    rd_ok(6, 64'hFFFF_FC00_0000_1000, "R9 kstack read priv");

    acc(1'b1, 16, 64'h0, 64'd0, 64'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R10 inval all");
    acc(1'b1, 17, 64'h0, 64'd0, 64'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R10 inval all proc");
    acc(1'b1, 18, 64'h0000_0000_1234_6000, 64'd0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R10 inval one");
    acc(1'b1, 19, 64'h0000_0001_0000_2000, 64'd0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R10 inval one data");
    acc(1'b1, 20, 64'hFFFF_FFFF_8000_0000, 64'd0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R10 inval one instr");

    bad(1'b1, 31, "R11 unknown write");
    bad(1'b0, 31, "R11 unknown read");
    bad(1'b1, 27, "R11 unknown write 27");
    rd_ok(5, 64'd5, "R11 prio unchanged");
    rd_ok(1, 64'd2, "R11 trap enable unchanged");

    wr_ok(9, 64'h1111_2222_3333_4444, "R12 cpu base write");
    rd_ok(9, 64'h1111_2222_3333_4444, "R12 cpu base read");
    wr_ok(14, 64'h5555_0000_0000_0001, "R12 sstack write");
    wr_ok(21, 64'h0000_0000_7FFF_0000, "R12 ustack write");
    wr_ok(25, 64'h8000_0000_0000_0008, "R12 estack write");
    wr_ok(23, 64'hFFFF_FFFE_0000_0000, "R12 vptb write");
    rd_ok(14, 64'h5555_0000_0000_0001, "R12 sstack read");
    rd_ok(21, 64'h0000_0000_7FFF_0000, "R12 ustack read");
    rd_ok(25, 64'h8000_0000_0000_0008, "R12 estack read");
    rd_ok(23, 64'hFFFF_FFFE_0000_0000, "R12 vptb read");
    wr_old(26, ONES, 64'd0, "R12 perf write");
    rd_ok(26, 64'd0, "R12 perf read");
    rd_ok(10, 64'h0000_0123_4560_0000, "R12 ptb read");
    rd_ok(24, 64'h3, "R12 cpu id read");
    wr_ok(3, 64'h0, "R13 write without old");

    repeat (4) @(posedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R1 missing responses actual=%0d expected=0", exp_q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule